// File: doc/BRIEF.md
# Sub-Word Load/Store Lane Unit

This block connects a load/store port to a small memory organised as rows of eight bytes. Each request names a byte address, an access size of 1, 2, 4 or 8 bytes, a direction and a swap enable. The block splits the address into a row index and a byte offset within the row. It checks that the offset is a multiple of the access size. On a load it extracts the addressed byte lane. On a store it merges new data into that lane and keeps the other bytes of the row.

When the swap enable is set, the block reverses the byte order inside the access size. A store reverses the data before it is written. A load reverses the data after the lane is extracted. A misaligned request does not complete and is reported through an error flag. The row array is internal. Reset clears it, and a caller or a testbench fills it through ordinary store requests.

A small state machine holds the kind of response that is due. It has four states:
- `RSP_NONE`: no response is due.
- `RSP_LOAD`: a load result is due.
- `RSP_STORE`: a store acknowledge is due.
- `RSP_FAULT`: a misalignment error is due.

On every clock edge, the next state is chosen as follows:
- `RSP_NONE` when no request is valid.
- `RSP_FAULT` when the request is misaligned.
- `RSP_STORE` for an aligned store.
- `RSP_LOAD` for an aligned load.

Every state can move to any of these four.

Top module: `sublane_lsu`

## Requirements
- R1: The byte offset is address bits [2:0]. The row index is address bits [2+log2(ROWS):3], which is (address >> 3) modulo ROWS (ROWS = 16). Higher address bits are ignored, so addresses wrap onto the array.
- R2: A request whose offset is not a multiple of its size gives rsp_err = 1 and rsp_rdata = 0 one cycle later. A misaligned store leaves every row unchanged.
- R3: A load without swap returns the addressed lane zero-extended to 64 bits. Byte 0 of a row is its least significant byte, and a lane starts at bit offset × 8. The size code is 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes.
- R4: A store of fewer than 8 bytes replaces only the addressed lane of the row and preserves the other bytes. Write-data bits above the access size are ignored.
- R5: A store with req_swap = 1 writes its data with the byte order reversed within the access size.
- R6: A load with req_swap = 1 returns the extracted lane with its byte order reversed within the access size, still zero-extended.
- R7: An 8-byte access at offset 0 reads or writes the whole row with no masking.
- R8: A row not written since reset reads as zero.
- R9: rsp_valid is 1 exactly in the cycle after a cycle with req_valid = 1, and 0 otherwise, including right after reset. Back-to-back requests each get a response.
- R10: An aligned store responds with rsp_err = 0 and rsp_rdata = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; clears the rows and the response |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Size code: 0 = 1 byte, 1 = 2, 2 = 4, 3 = 8 |
| req_addr | input | 64 | Byte address |
| req_wdata | input | 64 | Store data, right-aligned |
| req_swap | input | 1 | Reverse byte order within the access size |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 64 | Load result, zero-extended; zero for stores and faults |
| rsp_err | output | 1 | Misalignment error |

## Verification
The hardest case to reach from the ports is the proof that a rejected store touched nothing. The bench can only see this by reading the row back later. It therefore follows each misaligned store with a full-row load of the same row and compares against a row image built from earlier stores. A second hard case is address wrap. The stimulus aims stores at addresses with high bits set, or with row numbers beyond the array, and then reads the aliased row through a plain low address.

// File: rtl/sublane_pkg.sv
package sublane_pkg;
    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_LOAD  = 2'd1,
        RSP_STORE = 2'd2,
        RSP_FAULT = 2'd3
    } rsp_state_e;
endpackage

// File: rtl/sublane_addr_split.sv
module sublane_addr_split #(
    parameter int ADDR_W    = 64,
    parameter int ROW_BYTES = 8,
    parameter int ROWS      = 16,
    parameter int SIZE_W    = 2
) (
    input  logic [ADDR_W-1:0]            addr,
    input  logic [SIZE_W-1:0]            size,
    output logic [$clog2(ROWS)-1:0]      row_idx,
    output logic [$clog2(ROW_BYTES)-1:0] offset,
    output logic                         misaligned
);
    localparam int OFS_W = $clog2(ROW_BYTES);
    localparam int IDX_W = $clog2(ROWS);

    logic [OFS_W-1:0] size_lowmask;
    logic             unused_high_addr;

    assign offset  = addr[OFS_W-1:0];
    assign row_idx = addr[OFS_W +: IDX_W];
    assign unused_high_addr = ^addr[ADDR_W-1:OFS_W+IDX_W];

    always_comb begin
        size_lowmask = '0;
        for (int b = 0; b < OFS_W; b++) begin
            if (int'(size) > b) size_lowmask[b] = 1'b1;
        end
    end

    assign misaligned = |(offset & size_lowmask);
endmodule

// File: rtl/sublane_swap.sv
module sublane_swap #(
    parameter int ROW_BYTES = 8,
    parameter int SIZE_W    = 2
) (
    input  logic [ROW_BYTES*8-1:0] din,
    input  logic [SIZE_W-1:0]      size,
    input  logic                   enable,
    output logic [ROW_BYTES*8-1:0] dout
);
    int nbytes;

    always_comb begin
        nbytes = 1 << size;
        if (enable) begin
            dout = '0;
            for (int i = 0; i < ROW_BYTES; i++) begin
                if (i < nbytes) dout[i*8 +: 8] = din[(nbytes-1-i)*8 +: 8];
            end
        end else begin
            dout = din;
        end
    end
endmodule

// File: rtl/sublane_rows.sv
module sublane_rows #(
    parameter int ROW_BYTES = 8,
    parameter int ROWS      = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [$clog2(ROWS)-1:0] rd_idx,
    output logic [ROW_BYTES*8-1:0]  rd_row,
    input  logic                    wr_en,
    input  logic [$clog2(ROWS)-1:0] wr_idx,
    input  logic [ROW_BYTES*8-1:0]  wr_row
);
    logic [ROW_BYTES*8-1:0] rows_q [ROWS];

    assign rd_row = rows_q[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++) rows_q[r] <= '0;
        end else if (wr_en) begin
            rows_q[wr_idx] <= wr_row;
        end
    end
endmodule

// File: rtl/sublane_lsu.sv
module sublane_lsu
    import sublane_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int ROW_BYTES = 8,
    parameter int ROWS      = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_store,
    input  logic [1:0]  req_size,
    input  logic [63:0] req_addr,
    input  logic [63:0] req_wdata,
    input  logic        req_swap,
    output logic        rsp_valid,
    output logic [63:0] rsp_rdata,
    output logic        rsp_err
);
    localparam int DATA_W = ROW_BYTES * 8;
    localparam int OFS_W  = $clog2(ROW_BYTES);
    localparam int IDX_W  = $clog2(ROWS);
    localparam int SIZE_W = 2;

    rsp_state_e state_q, state_d;
    logic [DATA_W-1:0] rdata_q, rdata_d;

    logic [IDX_W-1:0]  row_idx;
    logic [OFS_W-1:0]  offset;
    logic              misaligned;
    logic [DATA_W-1:0] cur_row, new_row;
    logic [DATA_W-1:0] lane_mask, placed_mask;
    logic [DATA_W-1:0] st_swapped, ld_lane, ld_result;
    logic              do_write;
    int                shift_bits;

    sublane_addr_split #(.ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES), .ROWS(ROWS), .SIZE_W(SIZE_W)) u_split (
        .addr(req_addr), .size(req_size),
        .row_idx(row_idx), .offset(offset), .misaligned(misaligned)
    );

    sublane_rows #(.ROW_BYTES(ROW_BYTES), .ROWS(ROWS)) u_rows (
        .clk(clk), .rst(rst),
        .rd_idx(row_idx), .rd_row(cur_row),
        .wr_en(do_write), .wr_idx(row_idx), .wr_row(new_row)
    );

    sublane_swap #(.ROW_BYTES(ROW_BYTES), .SIZE_W(SIZE_W)) u_st_swap (
        .din(req_wdata), .size(req_size), .enable(req_swap), .dout(st_swapped)
    );

    sublane_swap #(.ROW_BYTES(ROW_BYTES), .SIZE_W(SIZE_W)) u_ld_swap (
        .din(ld_lane), .size(req_size), .enable(req_swap), .dout(ld_result)
    );

    always_comb begin
        shift_bits = int'(offset) * 8;
        if ((1 << req_size) >= ROW_BYTES) lane_mask = '1;
        else lane_mask = (DATA_W'(1) << ((1 << req_size) * 8)) - DATA_W'(1);
        placed_mask = lane_mask << shift_bits;
        new_row     = (cur_row & ~placed_mask) | ((st_swapped & lane_mask) << shift_bits);
        ld_lane     = (cur_row >> shift_bits) & lane_mask;
        do_write    = req_valid && req_store && !misaligned;
    end

    always_comb begin
        state_d = RSP_NONE;
        rdata_d = '0;
        if (req_valid) begin
            if (misaligned)     state_d = RSP_FAULT;
            else if (req_store) state_d = RSP_STORE;
            else begin
                state_d = RSP_LOAD;
                rdata_d = ld_result;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RSP_NONE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= rdata_d;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        unique case (state_q)
            RSP_NONE:  ;
            RSP_LOAD:  begin rsp_valid = 1'b1; rsp_rdata = rdata_q; end
            RSP_STORE: rsp_valid = 1'b1;
            RSP_FAULT: begin rsp_valid = 1'b1; rsp_err = 1'b1; end
            default:   ;
        endcase
    end

    assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    assert_no_spurious_rsp_R9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    assert_misalign_flagged_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && misaligned) |=> (rsp_err && rsp_rdata == '0));
    assert_fault_blocks_write_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && misaligned) |-> !do_write);
    assert_store_ack_clean_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_store && !misaligned) |=> (!rsp_err && rsp_rdata == '0));
    assert_byte_zero_extend_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_store && req_size == 2'd0) |=> (rsp_rdata[63:8] == '0));
endmodule

// File: tb/tb_sublane_lsu.sv
`timescale 1ns/1ps
module tb_sublane_lsu;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_store, req_swap;
    logic [1:0]  req_size;
    logic [63:0] req_addr, req_wdata;
    logic        rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sublane_lsu dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_swap(req_swap), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err)
    );

    typedef struct packed {
        logic        st;
        logic [1:0]  sz;
        logic [63:0] addr;
        logic [63:0] wd;
        logic        sw;
        logic        err;
        logic [63:0] rd;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd3, 64'h00, 64'h1122334455667788, 1'b0, 1'b0, 64'h0},                // R7 R10
        '{1'b0, 2'd3, 64'h00, 64'h0, 1'b0, 1'b0, 64'h1122334455667788},                 // R7
        '{1'b0, 2'd0, 64'h01, 64'h0, 1'b0, 1'b0, 64'h77},                               // R3
        '{1'b0, 2'd1, 64'h06, 64'h0, 1'b0, 1'b0, 64'h1122},                             // R3
        '{1'b0, 2'd2, 64'h04, 64'h0, 1'b0, 1'b0, 64'h11223344},                         // R3
        '{1'b1, 2'd0, 64'h02, 64'hFFFFFFFFFFFFFFAB, 1'b0, 1'b0, 64'h0},                 // R4
        '{1'b0, 2'd3, 64'h00, 64'h0, 1'b0, 1'b0, 64'h1122334455AB7788},                 // R4
        '{1'b1, 2'd1, 64'h0C, 64'hBEEF, 1'b1, 1'b0, 64'h0},                             // R5
        '{1'b0, 2'd3, 64'h08, 64'h0, 1'b0, 1'b0, 64'h0000EFBE00000000},                 // R5
        '{1'b0, 2'd1, 64'h0C, 64'h0, 1'b1, 1'b0, 64'hBEEF},                             // R6
        '{1'b0, 2'd2, 64'h00, 64'h0, 1'b1, 1'b0, 64'h8877AB55},                         // R6
        '{1'b0, 2'd3, 64'h00, 64'h0, 1'b1, 1'b0, 64'h8877AB5544332211},                 // R6 R7
        '{1'b0, 2'd2, 64'h02, 64'h0, 1'b0, 1'b1, 64'h0},                                // R2
        '{1'b1, 2'd1, 64'h01, 64'hFFFF, 1'b0, 1'b1, 64'h0},                             // R2
        '{1'b0, 2'd3, 64'h00, 64'h0, 1'b0, 1'b0, 64'h1122334455AB7788},                 // R2 row kept
        '{1'b1, 2'd3, 64'h0F, 64'hFFFFFFFFFFFFFFFF, 1'b0, 1'b1, 64'h0},                 // R2
        '{1'b0, 2'd3, 64'h08, 64'h0, 1'b0, 1'b0, 64'h0000EFBE00000000},                 // R2 row kept
        '{1'b1, 2'd0, 64'h85, 64'h5A, 1'b0, 1'b0, 64'h0},                               // R1 wraps to row 0
        '{1'b0, 2'd3, 64'h00, 64'h0, 1'b0, 1'b0, 64'h11225A4455AB7788},                 // R1
        '{1'b0, 2'd0, 64'hFFFF000000000015, 64'h0, 1'b0, 1'b0, 64'h0},                  // R1 R8
        '{1'b1, 2'd0, 64'h1000000000000013, 64'h3C, 1'b0, 1'b0, 64'h0},                 // R1
        '{1'b0, 2'd2, 64'h10, 64'h0, 1'b0, 1'b0, 64'h3C000000},                         // R1
        '{1'b1, 2'd0, 64'h07, 64'h99, 1'b1, 1'b0, 64'h0},                               // R5 single byte
        '{1'b0, 2'd0, 64'h7F, 64'h0, 1'b0, 1'b0, 64'h0}                                 // R8
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic st, input logic [1:0] sz, input logic [63:0] a,
                         input logic [63:0] wd, input logic sw);
        req_valid = 1'b1; req_store = st; req_size = sz;
        req_addr = a; req_wdata = wd; req_swap = sw;
    endtask

    task automatic idle_inputs();
        req_valid = 1'b0; req_store = 1'b0; req_size = 2'd0;
        req_addr = '0; req_wdata = '0; req_swap = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #100000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset valid", 64'(rsp_valid), 64'h0);
        check("R9 reset err", 64'(rsp_err), 64'h0);
        check("R9 reset rdata", rsp_rdata, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R9 idle valid", 64'(rsp_valid), 64'h0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].st, VECS[i].sz, VECS[i].addr, VECS[i].wd, VECS[i].sw);
            @(negedge clk);
            check($sformatf("vector %0d valid", i), 64'(rsp_valid), 64'h1);
            check($sformatf("vector %0d err", i), 64'(rsp_err), 64'(VECS[i].err));
            check($sformatf("vector %0d rdata", i), rsp_rdata, VECS[i].rd);
            idle_inputs();
            @(negedge clk);
        end

        // R9: no response after an idle cycle
        check("R9 gap valid", 64'(rsp_valid), 64'h0);

        // R9: back-to-back store then load of the same row
        drive(1'b1, 2'd1, 64'h22, 64'hCAFE, 1'b0);
        @(negedge clk);
        check("R9 b2b store valid", 64'(rsp_valid), 64'h1);
        check("R10 b2b store rdata", rsp_rdata, 64'h0);
        drive(1'b0, 2'd3, 64'h20, 64'h0, 1'b0);
        @(negedge clk);
        check("R9 b2b load valid", 64'(rsp_valid), 64'h1);
        check("R4 b2b load rdata", rsp_rdata, 64'h00000000CAFE0000);
        idle_inputs();
        @(negedge clk);
        check("R9 b2b then idle", 64'(rsp_valid), 64'h0);

        // R8: reset clears the rows
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        drive(1'b0, 2'd3, 64'h00, 64'h0, 1'b0);
        @(negedge clk);
        check("R8 row0 after reset", rsp_rdata, 64'h0);
        drive(1'b0, 2'd3, 64'h20, 64'h0, 1'b0);
        @(negedge clk);
        check("R8 row4 after reset", rsp_rdata, 64'h0);
        idle_inputs();
        @(negedge clk);

        finish_run();
    end
endmodule